// File: doc/BRIEF.md
# Maskable Interrupt Mask Controller

This block governs the three maskable restart request lines of a small processor core. The lines are called 7.5, 6.5 and 5.5, and 7.5 has the highest priority. The instruction decoder drives the block through a command port. Each valid command marks one retired instruction. The commands are enable, disable, set-mask, read-mask and halt. Set-mask carries the accumulator byte, and read-mask returns a status byte one cycle later.

The block decides when an interrupt may be taken. It presents a request together with the restart address of the winning line. When the core acknowledges the request, the block clears the global enable and leaves the halted state. If line 7.5 was the one taken, it also drops the 7.5 latch.

The global enable is a three-state machine. IE_OFF moves to IE_ARMED on an enable command. IE_ARMED moves to IE_ON when the next instruction retires, or back to IE_OFF if that instruction is a disable. IE_ON returns to IE_OFF on a disable or on an acceptance. The run machine has two states. RUN_ACTIVE moves to RUN_HALTED on a halt command. RUN_HALTED returns to RUN_ACTIVE only on an acceptance.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the global enable is off, all three masks are 1, the 7.5 latch is clear, halted=0, int_req=0, rd_valid=0 and rd_data=0.
- R2: Command codes are: 0 no-op, 1 enable, 2 disable, 3 set-mask, 4 read-mask, 5 halt, and 6 and 7 retire as no-ops. Disable turns the enable off at once. Enable arms it, and the enable turns on only when the next command retires, unless that command is a disable.
- R3: Set-mask with acc bit3=1 loads the masks from acc bit0 (5.5), bit1 (6.5) and bit2 (7.5). A mask bit of 1 blocks its line. With bit3=0 the masks are left unchanged.
- R4: Set-mask with acc bit4=1 clears the 7.5 latch, whatever the value of bit3.
- R5: Read-mask gives rd_valid=1 in the next cycle. rd_data then holds bits 2:0 = masks, bit3 = global enable, bit4 = 5.5 level, bit5 = 6.5 level, bit6 = 7.5 latch and bit7 = 0, all sampled at the command. rd_data holds that value until the next read.
- R6: A rising edge on irq75_in sets the 7.5 latch. The latch stays set after the input falls, and it is set even while 7.5 is masked. Lines 6.5 and 5.5 are level inputs.
- R7: The winning pending line is chosen in the order 7.5, 6.5, 5.5. int_vector is 003Ch, 0034h or 002Ch for these lines, and 0 when there is no request.
- R8: int_req is 1 exactly when the enable is on and some line is both pending and unmasked. int_ack while int_req is high accepts the request: the enable turns off, the block leaves halt, and the 7.5 latch clears if 7.5 won.
- R9: A halt command sets halted. While halted, every command is ignored. Only an acceptance or reset leaves halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One instruction retires with cmd_op |
| cmd_op | input | 3 | Command code (R2) |
| cmd_acc | input | 8 | Accumulator byte for set-mask |
| irq75_in | input | 1 | Edge-latched restart line 7.5 |
| irq65_in | input | 1 | Level restart line 6.5 |
| irq55_in | input | 1 | Level restart line 5.5 |
| int_ack | input | 1 | Core takes the presented interrupt |
| int_req | output | 1 | Interrupt request |
| int_vector | output | 16 | Restart address of the winning line |
| halted | output | 1 | Core is halted |
| rd_valid | output | 1 | Read-mask result valid |
| rd_data | output | 8 | Read-mask status byte |

## Verification
The bench aims at the one-instruction delay after enable. A design that turns the enable on at once would raise int_req a cycle early. The bench also targets a disable that immediately follows an enable: a design that lets the armed state win would grant an interrupt it should block. The bench pulses 7.5 while that line is masked and then clears it with bit4 alone; a level-sensitive or mask-gated latch loses the pending bit, and a design that demands bit3 for the clear keeps a stale bit. Finally, the bench issues commands while halted and exits halt by acknowledgement; a design that obeys those commands, or leaves halt by itself, shows a wrong enable, a wrong halted output or a stray read result.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_EI   = 3'd1,
        OP_DI   = 3'd2,
        OP_SETM = 3'd3,
        OP_READ = 3'd4,
        OP_HALT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        IE_OFF   = 2'd0,
        IE_ARMED = 2'd1,
        IE_ON    = 2'd2
    } ie_state_e;

    typedef enum logic {
        RUN_ACTIVE = 1'b0,
        RUN_HALTED = 1'b1
    } run_state_e;

    localparam int NUM_LINES = 3;
endpackage

// File: rtl/irqm_ie_fsm.sv
module irqm_ie_fsm
    import irqm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic is_ei,
    input  logic is_di,
    input  logic accept,
    output logic ie_on
);
    ie_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IE_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IE_OFF:   if (retire && is_ei && !accept) state_nx = IE_ARMED;
            IE_ARMED: if (accept || (retire && is_di)) state_nx = IE_OFF;
                      else if (retire)                 state_nx = IE_ON;
            IE_ON:    if (accept || (retire && is_di)) state_nx = IE_OFF;
            default:  state_nx = IE_OFF;
        endcase
    end

    always_comb ie_on = (state == IE_ON);

    // R8
    accept_drops_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state != IE_ON));
    // R2
    ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IE_OFF) |=> (state != IE_ON));
endmodule

// File: rtl/irqm_halt_fsm.sv
module irqm_halt_fsm
    import irqm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic is_halt,
    input  logic accept,
    output logic halted
);
    run_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RUN_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RUN_ACTIVE: if (retire && is_halt && !accept) state_nx = RUN_HALTED;
            RUN_HALTED: if (accept)                       state_nx = RUN_ACTIVE;
            default:    state_nx = RUN_ACTIVE;
        endcase
    end

    always_comb halted = (state == RUN_HALTED);

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RUN_HALTED && !accept) |=> (state == RUN_HALTED));
endmodule

// File: rtl/irqm_prio.sv
module irqm_prio
    import irqm_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] VEC_HI = 16'h003C,
    parameter logic [15:0] VEC_MD = 16'h0034,
    parameter logic [15:0] VEC_LO = 16'h002C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    input  logic                 ie_on,
    output logic                 req,
    output logic [NUM_LINES-1:0] grant,
    output logic [ADDR_W-1:0]    vector
);
    logic [NUM_LINES-1:0] act;

    always_comb begin
        act   = ie_on ? (pend & ~mask) : '0;
        grant = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        req = |act;
    end

    always_comb begin
        vector = '0;
        unique case (grant)
            3'b100:  vector = ADDR_W'(VEC_HI);
            3'b010:  vector = ADDR_W'(VEC_MD);
            3'b001:  vector = ADDR_W'(VEC_LO);
            default: vector = '0;
        endcase
    end

    // R7
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_on && pend[2] && !mask[2]) |-> (vector == ADDR_W'(VEC_HI)));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqm_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] VEC_75 = 16'h003C,
    parameter logic [15:0] VEC_65 = 16'h0034,
    parameter logic [15:0] VEC_55 = 16'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        cmd_acc,
    input  logic              irq75_in,
    input  logic              irq65_in,
    input  logic              irq55_in,
    input  logic              int_ack,
    output logic              int_req,
    output logic [ADDR_W-1:0] int_vector,
    output logic              halted,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int ACC_MSET = 3;
    localparam int ACC_CLR  = 4;

    logic                 retire, accept, ie_on, clr75, rise75;
    logic                 prev75, pend75;
    logic [NUM_LINES-1:0] mask, grant, pend;
    logic                 is_setm, is_read;

    always_comb begin
        retire  = cmd_valid && !halted;
        is_setm = retire && (cmd_op == OP_SETM);
        is_read = retire && (cmd_op == OP_READ);
        accept  = int_ack && int_req;
        rise75  = irq75_in && !prev75;
        clr75   = (is_setm && cmd_acc[ACC_CLR]) || (accept && grant[2]);
        pend    = {pend75, irq65_in, irq55_in};
    end

    irqm_ie_fsm u_ie (
        .clk(clk), .rst_n(rst_n), .retire(retire),
        .is_ei(cmd_op == OP_EI), .is_di(cmd_op == OP_DI),
        .accept(accept), .ie_on(ie_on)
    );

    irqm_halt_fsm u_halt (
        .clk(clk), .rst_n(rst_n), .retire(retire),
        .is_halt(cmd_op == OP_HALT), .accept(accept), .halted(halted)
    );

    irqm_prio #(.ADDR_W(ADDR_W), .VEC_HI(VEC_75), .VEC_MD(VEC_65), .VEC_LO(VEC_55)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .ie_on(ie_on),
        .req(int_req), .grant(grant), .vector(int_vector)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= '1;
            prev75   <= 1'b0;
            pend75   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            prev75   <= irq75_in;
            pend75   <= rise75 || (pend75 && !clr75);
            rd_valid <= is_read;
            if (is_setm && cmd_acc[ACC_MSET]) mask <= cmd_acc[NUM_LINES-1:0];
            if (is_read) rd_data <= {1'b0, pend, ie_on, mask};
        end
    end

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && (cmd_op == OP_READ) && !halted));
    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend75 && !clr75) |=> pend75);
endmodule

// File: tb/tb_irq_mask_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mask_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, irq75_in = 0, irq65_in = 0, irq55_in = 0, int_ack = 0;
    logic [2:0] cmd_op = 0;
    logic [7:0] cmd_acc = 0;
    logic int_req, halted, rd_valid;
    logic [15:0] int_vector;
    logic [7:0] rd_data;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_ie = 0;            // 0 off, 1 armed, 2 on
    bit m_halt = 0, m_p75 = 0, m_prev = 0, m_rdv = 0;
    bit [2:0] m_mask = 3'b111;
    bit [7:0] m_rd = 0;

    always #4 clk = ~clk;

    irq_mask_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_acc(cmd_acc), .irq75_in(irq75_in), .irq65_in(irq65_in),
        .irq55_in(irq55_in), .int_ack(int_ack), .int_req(int_req),
        .int_vector(int_vector), .halted(halted), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", rq, act, exp, cycles);
        end
    endtask

    function automatic int m_vec();
        bit [2:0] a;
        a = {m_p75, irq65_in, irq55_in} & ~m_mask;
        if (m_ie != 2) return 0;
        if (a[2]) return 'h3C;
        if (a[1]) return 'h34;
        if (a[0]) return 'h2C;
        return 0;
    endfunction

    task automatic compare();
        chk("R8 int_req", int_req, m_vec() != 0);
        chk("R7 int_vector", int_vector, m_vec());
        chk("R9 halted", halted, m_halt);
        chk("R5 rd_valid", rd_valid, m_rdv);
        chk("R5 rd_data", rd_data, m_rd);
    endtask

    task automatic step(bit v, int op, bit [7:0] acc, bit l75, bit l65, bit l55, bit ack);
        bit ok, ret, rise, clr;
        int vec;
        cmd_valid = v; cmd_op = 3'(op); cmd_acc = acc;
        irq75_in = l75; irq65_in = l65; irq55_in = l55; int_ack = ack;
        @(posedge clk);
        vec  = m_vec();
        ok   = ack && (vec != 0);
        ret  = v && !m_halt;
        rise = l75 && !m_prev;
        clr  = (ret && op == 3 && acc[4]) || (ok && vec == 'h3C);
        m_rdv = ret && op == 4;
        if (m_rdv) m_rd = {1'b0, m_p75, l65, l55, (m_ie == 2), m_mask};
        if (ret && op == 3 && acc[3]) m_mask = acc[2:0];
        m_p75  = rise || (m_p75 && !clr);
        m_prev = l75;
        if (ok) m_ie = 0;
        else if (ret) begin
            if (op == 2) m_ie = 0;
            else if (m_ie == 1) m_ie = 2;
            else if (op == 1 && m_ie == 0) m_ie = 1;
        end
        if (ok) m_halt = 0;
        else if (ret && op == 5) m_halt = 1;
        @(negedge clk);
        cycles++;
        compare();
    endtask

    task automatic cmd(int op, bit [7:0] acc);
        step(1, op, acc, irq75_in, irq65_in, irq55_in, 0);
    endtask

    task automatic idle();
        step(0, 0, 0, irq75_in, irq65_in, irq55_in, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_req", int_req, 0);
        chk("R1 halted", halted, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmd(4, 0);
        chk("R1 read masks all set", rd_data, 8'h07);
        // R3 bit3 clear leaves masks
        cmd(3, 8'h00); cmd(4, 0);
        chk("R3 masks unchanged", rd_data, 8'h07);
        cmd(3, 8'h08); cmd(4, 0);
        chk("R3 masks cleared", rd_data, 8'h00);
        // R2 enable delay
        step(1, 1, 0, 0, 0, 1, 0);
        chk("R2 armed no req", int_req, 0);
        cmd(0, 0);
        chk("R2 req after next instr", int_req, 1);
        chk("R7 vector 5.5", int_vector, 16'h002C);
        step(0, 0, 0, 0, 1, 1, 0);
        chk("R7 vector 6.5", int_vector, 16'h0034);
        step(0, 0, 0, 1, 1, 1, 0);
        step(0, 0, 0, 0, 1, 1, 0);
        chk("R6 7.5 latched after fall", int_vector, 16'h003C);
        step(0, 0, 0, 0, 1, 1, 1);
        chk("R8 accept drops req", int_req, 0);
        cmd(4, 0);
        chk("R8 read after accept", rd_data, 8'h30);
        // R6 latch while masked, R4 clear via bit4 alone
        cmd(3, 8'h0C);
        step(0, 0, 0, 1, 0, 0, 0);
        idle();
        cmd(4, 0);
        chk("R6 masked latch pending", rd_data, 8'h44);
        cmd(3, 8'h10); cmd(4, 0);
        chk("R4 latch cleared", rd_data, 8'h04);
        // R2 disable right after enable
        step(0, 0, 0, 0, 0, 0, 0);
        cmd(3, 8'h08);
        step(1, 1, 0, 0, 0, 1, 0);
        cmd(2, 0); idle();
        chk("R2 DI after EI blocks", int_req, 0);
        // R9 halt, ignored commands, exit on accept
        step(1, 1, 0, 0, 0, 0, 0); cmd(0, 0);
        cmd(5, 0);
        chk("R9 halted", halted, 1);
        cmd(2, 0); cmd(4, 0);
        chk("R9 read ignored", rd_valid, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R9 enable kept while halted", int_req, 1);
        step(0, 0, 0, 0, 0, 1, 1);
        chk("R9 exit by accept", halted, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 7);
            if (op == 5 && $urandom_range(0, 3) != 0) op = 0;
            step($urandom_range(0, 1), op, 8'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end
        rst_n = 1'b0;
        @(negedge clk);
        m_ie = 0; m_halt = 0; m_p75 = 0; m_prev = 0; m_rdv = 0; m_mask = 3'b111; m_rd = 0;
        chk("R1 reset after traffic", halted, 0);
        finish_run();
    end
endmodule